// File: doc/BRIEF.md
# Modem Status and Control Logic

This block holds the modem status byte of a serial port controller and drives its modem-control outputs. Four active-low handshake inputs (clear-to-send, data-set-ready, ring and carrier) are synchronised to the core clock. Their levels are reported as active-high bits. Each input also has a sticky change flag that stays set until software reads the status byte. An enabled change raises an interrupt request, which is held until the status byte is read.

On the output side, the block turns the control-register bits into the active-low terminal-ready and request-to-send pins. Both pins are forced inactive during loopback. Request-to-send is also forced inactive when automatic flow control sees the receiver above its threshold. A third control bit selects the interrupt-pin mode. When the bit is set, the pin is actively driven and the general-purpose output is low. When it is clear, the pin is tri-stated and the output is high. All outputs are registered.

Top module: `modem_ctl`

## Requirements
- R1: Status bits 4, 5, 6 and 7 read 1 while CTS, DSR, RI and CD (in that order) are low on their pins. The level appears SYNC_STAGES clock edges after the pin changes (2 by default).
- R2: Status bits 0, 1 and 3 are set when the synchronised CTS, DSR and CD level changes in either direction. The flag is set one edge after the new level shows in R1, and it stays set until a read.
- R3: Status bit 2 is set only when the RI pin returns from low to high, that is when status bit 6 goes from 1 to 0. The opposite transition never sets it.
- R4: When the read strobe is high at a clock edge, that edge clears status bits 0 to 3. A change detected at that same edge still sets its flag.
- R5: With the interrupt enable high, a DSR, CD or trailing-RI change raises the request. A CTS change raises it only while auto-CTS is off. The request is set at the same edge as the flag and holds until a read edge with no new event, or until reset. With the enable low, no request is raised.
- R6: The DTR and RTS outputs are registered and active low. Each goes low one edge after its control bit is 1. Both are high while loopback is set.
- R7: While auto-RTS is enabled and the receiver hold input is high, the RTS output is forced high one edge later, whatever the control bit says.
- R8: With the OUT control bit at 1, the interrupt output enable is 1 and OP is 0. With it at 0, the enable is 0 and OP is 1. Both take effect one edge after the bit changes.
- R9: During reset, the status byte is 0x00 and the request is 0. DTR, RTS and OP are 1 and the interrupt output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cts_ni | input | 1 | Clear-to-send pin, active low |
| dsr_ni | input | 1 | Data-set-ready pin, active low |
| ri_ni | input | 1 | Ring pin, active low |
| cd_ni | input | 1 | Carrier pin, active low |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| auto_cts_i | input | 1 | Auto-CTS flow control enabled |
| auto_rts_i | input | 1 | Auto-RTS flow control enabled |
| rx_hold_i | input | 1 | Receiver above threshold, asks RTS inactive |
| loop_i | input | 1 | Loopback mode |
| mcr_dtr_i | input | 1 | Control bit: terminal ready |
| mcr_rts_i | input | 1 | Control bit: request to send |
| mcr_out_i | input | 1 | Control bit 3: interrupt-pin mode and OP |
| msr_rd_i | input | 1 | Status-register read strobe |
| msr_o | output | 8 | Status byte |
| ms_irq_o | output | 1 | Modem-status interrupt request |
| dtr_no | output | 1 | Terminal-ready output, active low |
| rts_no | output | 1 | Request-to-send output, active low |
| op_o | output | 1 | General-purpose output |
| irq_oe_o | output | 1 | Interrupt pin drive enable (0 = tri-state) |

## Verification
A pin change shows in the level bits two edges later, and in the change flags and the request three edges later. The control outputs follow their inputs one edge later. The bench drives inputs only on falling clock edges. On each falling edge it compares every output against a reference whose registers advance on rising edges with those same latencies, so every comparison lands in the cycle the result is due. Directed cases place a read strobe on the exact edge where a change flag is set, and check the flag one and two edges after that.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int unsigned N_MODEM = 4;
  localparam int unsigned IDX_CTS = 0;
  localparam int unsigned IDX_DSR = 1;
  localparam int unsigned IDX_RI  = 2;
  localparam int unsigned IDX_CD  = 3;
  typedef logic [N_MODEM-1:0] modem_vec_t;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else if (STAGES == 1) chain_q <= d_i[b];
      else chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[LAST];
  end
endmodule

// File: rtl/modem_msr.sv
module modem_msr
  import modem_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  modem_vec_t lvl_i,
  input  logic       rd_i,
  input  logic       msi_en_i,
  input  logic       auto_cts_i,
  output logic [7:0] msr_o,
  output modem_vec_t ev_o,
  output logic       irq_o
);
  modem_vec_t prev_q, delta_q, ev;
  logic       irq_q, irq_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < N_MODEM; i++) begin : g_ev
    if (i == IDX_RI) begin : g_trail
      // ring: only the end of the active phase counts
      assign ev[i] = prev_q[i] & ~lvl_i[i];
    end else begin : g_any
      assign ev[i] = prev_q[i] ^ lvl_i[i];
    end
  end

  always_comb begin
    irq_set = 1'b0;
    for (int i = 0; i < N_MODEM; i++) begin
      if (i == IDX_CTS) irq_set |= ev[i] & ~auto_cts_i;
      else              irq_set |= ev[i];
    end
    irq_set &= msi_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      delta_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      delta_q <= (rd_i ? '0 : delta_q) | ev;
      irq_q   <= (irq_q & ~rd_i) | irq_set;
    end
  end

  assign msr_o = {lvl_i, delta_q};
  assign ev_o  = ev;
  assign irq_o = irq_q;
endmodule

// File: rtl/modem_outs.sv
module modem_outs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic loop_i,
  input  logic auto_rts_i,
  input  logic rx_hold_i,
  input  logic mcr_dtr_i,
  input  logic mcr_rts_i,
  input  logic mcr_out_i,
  output logic dtr_no,
  output logic rts_no,
  output logic op_o,
  output logic irq_oe_o
);
  logic dtr_act, rts_act;

  assign dtr_act = mcr_dtr_i & ~loop_i;
  assign rts_act = mcr_rts_i & ~loop_i & ~(auto_rts_i & rx_hold_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dtr_no   <= 1'b1;
      rts_no   <= 1'b1;
      op_o     <= 1'b1;
      irq_oe_o <= 1'b0;
    end else begin
      dtr_no   <= ~dtr_act;
      rts_no   <= ~rts_act;
      op_o     <= ~mcr_out_i;
      irq_oe_o <= mcr_out_i;
    end
  end
endmodule

// File: rtl/modem_ctl.sv
module modem_ctl
  import modem_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cts_ni,
  input  logic       dsr_ni,
  input  logic       ri_ni,
  input  logic       cd_ni,
  input  logic       msi_en_i,
  input  logic       auto_cts_i,
  input  logic       auto_rts_i,
  input  logic       rx_hold_i,
  input  logic       loop_i,
  input  logic       mcr_dtr_i,
  input  logic       mcr_rts_i,
  input  logic       mcr_out_i,
  input  logic       msr_rd_i,
  output logic [7:0] msr_o,
  output logic       ms_irq_o,
  output logic       dtr_no,
  output logic       rts_no,
  output logic       op_o,
  output logic       irq_oe_o
);
  modem_vec_t pin_act, lvl, ev;

  assign pin_act = ~{cd_ni, ri_ni, dsr_ni, cts_ni};

  modem_sync #(.WIDTH(N_MODEM), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_act), .q_o(lvl)
  );

  modem_msr u_msr (
    .clk_i, .rst_ni, .lvl_i(lvl), .rd_i(msr_rd_i), .msi_en_i,
    .auto_cts_i, .msr_o, .ev_o(ev), .irq_o(ms_irq_o)
  );

  modem_outs u_outs (
    .clk_i, .rst_ni, .loop_i, .auto_rts_i, .rx_hold_i,
    .mcr_dtr_i, .mcr_rts_i, .mcr_out_i,
    .dtr_no, .rts_no, .op_o, .irq_oe_o
  );
endmodule

// File: rtl/modem_ctl_chk.sv
module modem_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       msr_rd_i,
  input logic       loop_i,
  input logic       auto_rts_i,
  input logic       rx_hold_i,
  input logic       mcr_out_i,
  input logic       msi_en_i,
  input logic [3:0] ev,
  input logic [7:0] msr_o,
  input logic       ms_irq_o,
  input logic       dtr_no,
  input logic       rts_no,
  input logic       op_o,
  input logic       irq_oe_o
);
  p_ri_trail_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msr_o[2]) |-> ($past(msr_o[6], 2) && !$past(msr_o[6])));

  p_read_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_rd_i && ev == 4'b0) |=> (msr_o[3:0] == 4'b0));

  p_read_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_rd_i && ev[0]) |=> msr_o[0]);

  p_irq_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ms_irq_o && !msr_rd_i) |=> ms_irq_o);

  p_irq_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ms_irq_o && !msi_en_i) |=> !ms_irq_o);

  p_loop_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_i |=> (dtr_no && rts_no));

  p_auto_rts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_rts_i && rx_hold_i) |=> rts_no);

  p_out_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_out_i |=> (irq_oe_o && !op_o));
endmodule

bind modem_ctl modem_ctl_chk u_chk (
  .clk_i, .rst_ni, .msr_rd_i, .loop_i, .auto_rts_i, .rx_hold_i, .mcr_out_i,
  .msi_en_i, .ev, .msr_o, .ms_irq_o, .dtr_no, .rts_no, .op_o, .irq_oe_o
);

// File: tb/modem_ctl_bench.sv
module modem_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
  logic msi_en = 1'b0, auto_cts = 1'b0, auto_rts = 1'b0, rx_hold = 1'b0, loop_m = 1'b0;
  logic m_dtr = 1'b0, m_rts = 1'b0, m_out = 1'b0, rd = 1'b0;
  logic [7:0] msr;
  logic irq, dtr_n, rts_n, op, irq_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_ctl u_modem_ctl (
    .clk_i(clk), .rst_ni(rst_n), .cts_ni(cts_n), .dsr_ni(dsr_n), .ri_ni(ri_n), .cd_ni(cd_n),
    .msi_en_i(msi_en), .auto_cts_i(auto_cts), .auto_rts_i(auto_rts), .rx_hold_i(rx_hold),
    .loop_i(loop_m), .mcr_dtr_i(m_dtr), .mcr_rts_i(m_rts), .mcr_out_i(m_out),
    .msr_rd_i(rd), .msr_o(msr), .ms_irq_o(irq), .dtr_no(dtr_n), .rts_no(rts_n),
    .op_o(op), .irq_oe_o(irq_oe)
  );

  // reference: levels after two syncs, flags and request one edge later
  logic [3:0] r_s1, r_s2, r_s3, r_dl;
  logic r_irq, r_dtr, r_rts, r_op, r_oe;

  function automatic logic [3:0] ref_ev(input logic [3:0] now, input logic [3:0] old);
    ref_ev = now ^ old;
    ref_ev[2] = old[2] & ~now[2];
  endfunction

  function automatic logic ref_irq(input logic [3:0] e, input logic en, input logic acts);
    ref_irq = en & ((e[0] & ~acts) | e[1] | e[2] | e[3]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_s1 <= '0; r_s2 <= '0; r_s3 <= '0; r_dl <= '0; r_irq <= 1'b0;
      r_dtr <= 1'b1; r_rts <= 1'b1; r_op <= 1'b1; r_oe <= 1'b0;
    end else begin
      r_s1  <= ~{cd_n, ri_n, dsr_n, cts_n};
      r_s2  <= r_s1;
      r_s3  <= r_s2;
      r_dl  <= (rd ? 4'b0 : r_dl) | ref_ev(r_s2, r_s3);
      r_irq <= (r_irq & ~rd) | ref_irq(ref_ev(r_s2, r_s3), msi_en, auto_cts);
      r_dtr <= ~(m_dtr & ~loop_m);
      r_rts <= ~(m_rts & ~loop_m & ~(auto_rts & rx_hold));
      r_op  <= ~m_out;
      r_oe  <= m_out;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R1", {4'b0, msr[7:4]}, {4'b0, r_s2});
    chk("R2", {5'b0, msr[3], msr[1:0]}, {5'b0, r_dl[3], r_dl[1:0]});
    chk("R3", {7'b0, msr[2]}, {7'b0, r_dl[2]});
    chk("R5", {7'b0, irq}, {7'b0, r_irq});
    chk("R6", {7'b0, dtr_n}, {7'b0, r_dtr});
    chk("R7", {7'b0, rts_n}, {7'b0, r_rts});
    chk("R8", {6'b0, op, irq_oe}, {6'b0, r_op, r_oe});
  endtask

  task automatic tick();
    @(negedge clk);
    cmp_all();
  endtask

  initial begin
    void'($urandom(32'h1c0de5));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", msr, 8'h00);
    chk("R9", {4'b0, irq, dtr_n, rts_n, op}, {4'b0, 1'b0, 1'b1, 1'b1, 1'b1});
    chk("R9", {7'b0, irq_oe}, 8'h00);
    rst_n = 1'b1;
    tick();

    // R4: read lands on the edge that sets the CTS flag
    msi_en = 1'b1;
    cts_n = 1'b0;
    tick(); tick();
    chk("R1", {7'b0, msr[4]}, 8'h01);
    rd = 1'b1;
    tick();
    chk("R4", {7'b0, msr[0]}, 8'h01);
    chk("R4", {7'b0, irq}, 8'h01);
    tick();
    chk("R4", {4'b0, msr[3:0]}, 8'h00);
    chk("R5", {7'b0, irq}, 8'h00);
    rd = 1'b0;

    // R5: CTS change with auto-CTS gives a flag but no request
    auto_cts = 1'b1;
    cts_n = 1'b1;
    repeat (4) tick();
    chk("R2", {7'b0, msr[0]}, 8'h01);
    chk("R5", {7'b0, irq}, 8'h00);
    rd = 1'b1; tick(); rd = 1'b0; auto_cts = 1'b0;

    // R3: ring active edge sets nothing, trailing edge sets bit 2
    ri_n = 1'b0;
    repeat (4) tick();
    chk("R3", {7'b0, msr[2]}, 8'h00);
    ri_n = 1'b1;
    repeat (4) tick();
    chk("R3", {7'b0, msr[2]}, 8'h01);
    chk("R5", {7'b0, irq}, 8'h01);
    rd = 1'b1; tick(); rd = 1'b0;

    // R6/R7/R8 directed
    m_dtr = 1'b1; m_rts = 1'b1; m_out = 1'b1;
    tick();
    chk("R6", {6'b0, dtr_n, rts_n}, 8'h00);
    chk("R8", {6'b0, op, irq_oe}, 8'h01);
    auto_rts = 1'b1; rx_hold = 1'b1;
    tick();
    chk("R7", {6'b0, dtr_n, rts_n}, 8'h01);
    rx_hold = 1'b0; loop_m = 1'b1;
    tick();
    chk("R6", {6'b0, dtr_n, rts_n}, 8'h03);
    loop_m = 1'b0; m_out = 1'b0;
    tick();
    chk("R8", {6'b0, op, irq_oe}, 8'h02);

    // random phase
    for (int i = 0; i < N_RAND; i++) begin
      if ($urandom_range(7) == 0) cts_n = ~cts_n;
      if ($urandom_range(7) == 0) dsr_n = ~dsr_n;
      if ($urandom_range(7) == 0) ri_n  = ~ri_n;
      if ($urandom_range(7) == 0) cd_n  = ~cd_n;
      rd = ($urandom_range(5) == 0);
      if ($urandom_range(15) == 0) msi_en   = $urandom_range(1);
      if ($urandom_range(15) == 0) auto_cts = $urandom_range(1);
      if ($urandom_range(7) == 0)  auto_rts = $urandom_range(1);
      rx_hold = $urandom_range(1);
      if ($urandom_range(15) == 0) loop_m = $urandom_range(1);
      m_dtr = $urandom_range(1);
      m_rts = $urandom_range(1);
      if ($urandom_range(3) == 0) m_out = $urandom_range(1);
      tick();
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule